// File: doc/BRIEF.md
# Scanline-Interrupt Bank Controller

This block is one operating mode of a cartridge memory controller. The CPU programs it through writes to the upper half of its address space, and it produces the bank numbers that the surrounding memory logic uses to place program and pattern memory. A control register holds an index that picks one of eight writable bank registers. Two further control bits exchange the positions of two program windows, and of the two halves of pattern space. A single mirroring bit selects the nametable arrangement.

A signed scanline counter raises an interrupt request for the CPU. The counter is loaded directly or reloaded from a latch. It counts down on visible lines only while rendering is on. It raises the request when it is at or below zero and the interrupt is enabled, and then holds the request until software clears it. The counter never reloads itself.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset, the program slots read 0x3C, 0x3D, 0xFE, 0xFF. The pattern slots (1 KB units, slot 0 first) read 0, 1, 4, 5, 4, 5, 6, 7. mirrorHorz and irqOut are 0.
- R2: A write is decoded on (address AND 0xE001): 0x8000 control, 0x8001 bank data, 0xA000 mirroring, 0xC000 counter load, 0xC001 latch load, 0xE000 reload-and-disable, 0xE001 enable. Every other decoded value, such as 0xA001, changes nothing.
- R3: A bank-data write stores into register (control AND 7). Registers 0 and 1 store the data shifted right by one, and each one covers a pair of 1 KB slots numbered 2*stored and 2*stored+1 (mod 256). Registers 2 to 5 are 1 KB banks. Registers 8 and 9 are fixed at 0xFE and 0xFF.
- R4: With control bit 6 clear, program slots 0 to 3 take registers 6, 7, 8, 9. With bit 6 set, they take 8, 7, 6, 9.
- R5: With control bit 7 clear, pattern slots 0 to 3 come from registers 0 and 1, and slots 4 to 7 come from registers 2 to 5. With bit 7 set, the two groups exchange halves, so slot p shows what slot p XOR 4 would show.
- R6: mirrorHorz equals bit 0 of the last mirroring write (1 = horizontal, 0 = vertical).
- R7: A 0xC000 write loads the counter with the data. A 0xC001 write loads the latch. A 0xE000 write copies the latch into the counter, clears the enable and clears irqOut on the next cycle.
- R8: A 0xE001 write sets the interrupt enable.
- R9: On a line pulse with line number 0 to 239, the following applies. If the counter is at or below zero and the enable is set, irqOut is set and the counter keeps its value. Otherwise the counter decrements, but only when renderOn is 1. Pulses on lines above 239 have no effect.
- R10: Once set, irqOut stays high through further line pulses and through any write other than 0xE000.
- R11: The counter is a signed 9-bit value. Decrementing stops at -256 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | DATA_W | CPU write data |
| lineStrobe | input | 1 | One-cycle pulse per scanline |
| lineNum | input | LINE_W | Scanline number that goes with lineStrobe |
| renderOn | input | 1 | Rendering-enabled flag, sampled with lineStrobe |
| prgSlot | output | 4*DATA_W | 8 KB program bank numbers, slot 0 (lowest window) at the lowest bits |
| chrSlot | output | 8*DATA_W | 1 KB pattern bank numbers, slot 0 at the lowest bits |
| mirrorHorz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench uses the default build: DATA_W=8, CNT_W=9, LINE_W=9 and last visible line 239. At these sizes every writable register index can be swept against every combination of the two swap bits and a spread of data values, including the odd values whose lowest bit is dropped by the 2 KB shift. For each setting, all twelve bank outputs are compared with values computed from the mapping rules. The 9-bit counter is small enough to run reload values from 0 to 20, and 255, to the exact line on which the request rises. It is also small enough to drive the counter down to its negative limit, which shows saturation at -256 instead of wrap-around.

// File: rtl/bnkirq_pkg.sv
package bnkirq_pkg;

  localparam logic [15:0] DEC_MASK = 16'hE001;
  localparam logic [15:0] A_CTL    = 16'h8000;
  localparam logic [15:0] A_BANK   = 16'h8001;
  localparam logic [15:0] A_MIR    = 16'hA000;
  localparam logic [15:0] A_CNT    = 16'hC000;
  localparam logic [15:0] A_LAT    = 16'hC001;
  localparam logic [15:0] A_RELOAD = 16'hE000;
  localparam logic [15:0] A_ENABLE = 16'hE001;

  localparam int PRG_SLOTS = 4;
  localparam int CHR_SLOTS = 8;
  localparam int NUM_WREGS = 8;

  // one-cycle strobes from the decoder to the datapath
  typedef struct packed {
    logic ctlWr;
    logic bankWr;
    logic mirWr;
    logic cntLd;
    logic latLd;
    logic reloadOff;
    logic enOn;
    logic lineTick;
    logic renderOn;
  } strobe_t;

endpackage

// File: rtl/bnkirq_decode.sv
module bnkirq_decode
  import bnkirq_pkg::*;
#(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic              wrEn,
  input  logic [15:0]       wrAddr,
  input  logic              lineStrobe,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              renderOn,
  output strobe_t           stb
);

  logic [15:0] selAddr;
  logic        visible;

  assign selAddr = wrAddr & DEC_MASK;
  assign visible = (lineNum <= LINE_W'(LAST_LINE));

  always_comb begin
    stb           = '0;
    stb.ctlWr     = wrEn && (selAddr == A_CTL);
    stb.bankWr    = wrEn && (selAddr == A_BANK);
    stb.mirWr     = wrEn && (selAddr == A_MIR);
    stb.cntLd     = wrEn && (selAddr == A_CNT);
    stb.latLd     = wrEn && (selAddr == A_LAT);
    stb.reloadOff = wrEn && (selAddr == A_RELOAD);
    stb.enOn      = wrEn && (selAddr == A_ENABLE);
    stb.lineTick  = lineStrobe && visible;
    stb.renderOn  = renderOn;
  end

endmodule

// File: rtl/bnkirq_banks.sv
module bnkirq_banks
  import bnkirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             stb,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [PRG_SLOTS-1:0][DATA_W-1:0]    prgSlot,
  output logic [CHR_SLOTS-1:0][DATA_W-1:0]    chrSlot,
  output logic                                mirrorHorz
);

  localparam int SEL_W = $clog2(NUM_WREGS);
  localparam int HALF  = CHR_SLOTS / 2;
  localparam logic [DATA_W-1:0] FIXED_LO = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [DATA_W-1:0] FIXED_HI = {DATA_W{1'b1}};

  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    case (idx)
      0:       return DATA_W'(0);
      1:       return DATA_W'(2);
      2:       return DATA_W'(4);
      3:       return DATA_W'(5);
      4:       return DATA_W'(6);
      5:       return DATA_W'(7);
      6:       return DATA_W'(8'h3C);
      default: return DATA_W'(8'h3D);
    endcase
  endfunction

  logic [DATA_W-1:0] ctlReg;
  logic              mirReg;
  logic [SEL_W-1:0]  bankSel;
  logic              prgSwap;
  logic              chrSwap;
  logic [DATA_W-1:0] bankReg [NUM_WREGS];
  logic [CHR_SLOTS-1:0][DATA_W-1:0] chrLinear;

  assign bankSel = ctlReg[SEL_W-1:0];
  assign prgSwap = ctlReg[6];
  assign chrSwap = ctlReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      mirReg <= 1'b0;
    end else begin
      if (stb.ctlWr) ctlReg <= wrData;
      if (stb.mirWr) mirReg <= wrData[0];
    end
  end

  // writable bank registers; the two 2 KB ones keep data >> 1
  for (genvar g = 0; g < NUM_WREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nextVal;
    if (g < 2) begin : g_wide
      assign nextVal = wrData >> 1;
    end else begin : g_narrow
      assign nextVal = wrData;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= resetVal(g);
      else if (stb.bankWr && (bankSel == SEL_W'(g))) q <= nextVal;
    end
    assign bankReg[g] = q;
  end

  // pattern space before the half swap, in 1 KB units
  for (genvar k = 0; k < CHR_SLOTS; k++) begin : g_lin
    if (k < HALF) begin : g_pair
      assign chrLinear[k] = {bankReg[k/2][DATA_W-2:0], 1'(k % 2)};
    end else begin : g_single
      assign chrLinear[k] = bankReg[k-2];
    end
  end

  for (genvar p = 0; p < CHR_SLOTS; p++) begin : g_chr
    assign chrSlot[p] = chrSwap ? chrLinear[p ^ HALF] : chrLinear[p];
  end

  assign prgSlot[0]  = prgSwap ? FIXED_LO : bankReg[6];
  assign prgSlot[1]  = bankReg[7];
  assign prgSlot[2]  = prgSwap ? bankReg[6] : FIXED_LO;
  assign prgSlot[3]  = FIXED_HI;
  assign mirrorHorz  = mirReg;

endmodule

// File: rtl/bnkirq_scanline.sv
module bnkirq_scanline
  import bnkirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqOut
);

  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [CNT_W-1:0] cnt;
  logic [DATA_W-1:0]       latch;
  logic                    enable;
  logic                    irqReg;
  logic                    notAbove;

  assign notAbove = cnt[CNT_W-1] || (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      latch  <= '0;
      enable <= 1'b0;
      irqReg <= 1'b0;
    end else begin
      if (stb.latLd) latch  <= wrData;
      if (stb.enOn)  enable <= 1'b1;
      if (stb.reloadOff) begin
        cnt    <= CNT_W'(latch);
        enable <= 1'b0;
        irqReg <= 1'b0;
      end else if (stb.cntLd) begin
        cnt <= CNT_W'(wrData);
      end else if (stb.lineTick) begin
        if (notAbove && enable) begin
          irqReg <= 1'b1;
        end else if (stb.renderOn && (cnt != CNT_MIN)) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign irqOut = irqReg;

endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import bnkirq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [15:0]                      wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic                             lineStrobe,
  input  logic [LINE_W-1:0]                lineNum,
  input  logic                             renderOn,
  output logic [PRG_SLOTS-1:0][DATA_W-1:0] prgSlot,
  output logic [CHR_SLOTS-1:0][DATA_W-1:0] chrSlot,
  output logic                             mirrorHorz,
  output logic                             irqOut
);

  strobe_t stb;

  bnkirq_decode #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) i_decode (
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .lineStrobe (lineStrobe),
    .lineNum    (lineNum),
    .renderOn   (renderOn),
    .stb        (stb)
  );

  bnkirq_banks #(.DATA_W(DATA_W)) i_banks (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .prgSlot    (prgSlot),
    .chrSlot    (chrSlot),
    .mirrorHorz (mirrorHorz)
  );

  bnkirq_scanline #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_scanline (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/bnkirq_checker.sv
module bnkirq_checker
  import bnkirq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 239
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             wrEn,
  input logic [15:0]                      wrAddr,
  input logic                             lineStrobe,
  input logic [LINE_W-1:0]                lineNum,
  input logic [PRG_SLOTS-1:0][DATA_W-1:0] prgSlot,
  input logic [CHR_SLOTS-1:0][DATA_W-1:0] chrSlot,
  input logic                             mirrorHorz,
  input logic                             irqOut
);

  logic clearWr;
  logic mirWr;
  assign clearWr = wrEn && ((wrAddr & 16'hE001) == 16'hE000);
  assign mirWr   = wrEn && ((wrAddr & 16'hE001) == 16'hA000);

  // R9: a request only rises after a visible line pulse
  a_r9_irq_from_line: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(lineStrobe) && ($past(lineNum) <= LINE_W'(LAST_LINE))));

  // R7: reload write drops the request
  a_r7_reload_clears: assert property (@(posedge clk) disable iff (!rstN)
    clearWr |=> !irqOut);

  // R10: request held until a reload write
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clearWr) |=> irqOut);

  // R4 / R5: bank outputs move only after a write
  a_r4_banks_steady: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(prgSlot) && $stable(chrSlot)));

  // R6: mirroring changes only on its own write
  a_r6_mirror_steady: assert property (@(posedge clk) disable iff (!rstN)
    !mirWr |=> $stable(mirrorHorz));

endmodule

bind bank_irq_ctrl bnkirq_checker #(
  .DATA_W(DATA_W), .LINE_W(LINE_W), .LAST_LINE(LAST_LINE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .lineStrobe (lineStrobe),
  .lineNum    (lineNum),
  .prgSlot    (prgSlot),
  .chrSlot    (chrSlot),
  .mirrorHorz (mirrorHorz),
  .irqOut     (irqOut)
);

// File: tb/test_bank_irq_ctrl.sv
`timescale 1ns/1ps
module test_bank_irq_ctrl;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [15:0]     wrAddr = '0;
  logic [7:0]      wrData = '0;
  logic            lineStrobe = 1'b0;
  logic [8:0]      lineNum = '0;
  logic            renderOn = 1'b0;
  logic [3:0][7:0] prgSlot;
  logic [7:0][7:0] chrSlot;
  logic            mirrorHorz;
  logic            irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mreg[10];
  int mctl;

  always #10 clk = ~clk;

  bank_irq_ctrl i_bank_irq_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineStrobe(lineStrobe), .lineNum(lineNum), .renderOn(renderOn),
    .prgSlot(prgSlot), .chrSlot(chrSlot), .mirrorHorz(mirrorHorz), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 16'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int line, input bit rend);
    @(negedge clk);
    lineStrobe = 1'b1; lineNum = 9'(line); renderOn = rend;
    @(negedge clk);
    lineStrobe = 1'b0;
  endtask

  task automatic arm(input int v);
    wr(16'hC001, v);
    wr(16'hE000, 0);
    wr(16'hE001, 0);
  endtask

  function automatic int expPrg(input int s);
    bit sw = ((mctl >> 6) & 1) != 0;
    case (s)
      0: return sw ? mreg[8] : mreg[6];
      1: return mreg[7];
      2: return sw ? mreg[6] : mreg[8];
      default: return mreg[9];
    endcase
  endfunction

  function automatic int expChr(input int p);
    int k = (((mctl >> 7) & 1) != 0) ? (p ^ 4) : p;
    if (k < 4) return ((mreg[k/2] * 2) + (k % 2)) & 255;
    return mreg[k-2];
  endfunction

  task automatic checkMap(input string req);
    for (int s = 0; s < 4; s++) check(req, int'(prgSlot[s]), expPrg(s));
    for (int p = 0; p < 8; p++) check(req, int'(chrSlot[p]), expChr(p));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int dl[8] = '{0, 1, 2, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h5A};
    mreg = '{0, 2, 4, 5, 6, 7, 8'h3C, 8'h3D, 8'hFE, 8'hFF};
    mctl = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkMap("R1");
    check("R1 mirror", int'(mirrorHorz), 0);
    check("R1 irq", int'(irqOut), 0);

    // R3 R4 R5: sweep index, swap bits and data
    for (int idx = 0; idx < 8; idx++) begin
      for (int m = 0; m < 4; m++) begin
        for (int j = 0; j < 8; j++) begin
          mctl = (m << 6) | idx;
          wr(16'h8000, mctl);
          wr(16'h8001, dl[j]);
          mreg[idx] = (idx < 2) ? (dl[j] >> 1) : dl[j];
          checkMap("R3 R4 R5");
        end
      end
    end

    // R6 mirroring
    wr(16'hA000, 1);
    check("R6 horizontal", int'(mirrorHorz), 1);
    wr(16'hA000, 8'hFE);
    check("R6 vertical", int'(mirrorHorz), 0);

    // R2 decode on address AND 0xE001
    wr(16'hBFFE, 8'h03);
    check("R2 mirror alias", int'(mirrorHorz), 1);
    wr(16'hA001, 8'h00);
    check("R2 unused reg", int'(mirrorHorz), 1);
    checkMap("R2 unused reg");
    mctl = 8'h07;
    wr(16'h9FFE, mctl);
    wr(16'h9FFF, 8'h42);
    mreg[7] = 8'h42;
    checkMap("R2 bank alias");

    // R7 R8 R9 R10: reload values to exact line of request
    for (int v = 0; v <= 21; v++) begin
      int lv = (v == 21) ? 255 : v;
      arm(lv);
      for (int t = 0; t < lv; t++) tick(t % 240, 1'b1);
      check("R9 before zero", int'(irqOut), 0);
      tick(lv % 240, 1'b1);
      check("R9 at zero", int'(irqOut), 1);
      tick(5, 1'b1);
      check("R10 held", int'(irqOut), 1);
      wr(16'hC000, 9);
      wr(16'hE001, 0);
      check("R10 other writes", int'(irqOut), 1);
      wr(16'hE000, 0);
      check("R7 clear", int'(irqOut), 0);
    end

    // R9 render off holds the counter
    arm(1);
    for (int t = 0; t < 3; t++) tick(10, 1'b0);
    check("R9 render off", int'(irqOut), 0);
    tick(10, 1'b1);
    check("R9 render on reaches zero", int'(irqOut), 0);
    tick(11, 1'b0);
    check("R9 fire while render off", int'(irqOut), 1);

    // R9 lines above 239 ignored
    arm(0);
    tick(240, 1'b1);
    tick(300, 1'b1);
    check("R9 invisible line", int'(irqOut), 0);
    tick(239, 1'b1);
    check("R9 last visible line", int'(irqOut), 1);

    // R8 no request while disabled
    wr(16'hC001, 0);
    wr(16'hE000, 0);
    tick(3, 1'b1);
    check("R8 disabled", int'(irqOut), 0);
    wr(16'hE001, 0);
    tick(4, 1'b1);
    check("R8 enabled", int'(irqOut), 1);

    // R7 direct counter load
    arm(9);
    wr(16'hC000, 2);
    tick(1, 1'b1);
    tick(2, 1'b1);
    check("R7 direct load", int'(irqOut), 0);
    tick(3, 1'b1);
    check("R7 direct load fire", int'(irqOut), 1);

    // R11 saturation at -256
    arm(0);
    wr(16'hE000, 0);
    for (int t = 0; t < 300; t++) tick(t % 240, 1'b1);
    check("R11 disabled run", int'(irqOut), 0);
    wr(16'hE001, 0);
    tick(7, 1'b1);
    check("R11 saturated", int'(irqOut), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule